// File: doc/BRIEF.md
# Presence-Tagged Word Memory

This block is a small word-addressed store in which each word has one presence flag, marking it as either holding a value (full) or waiting for one (empty). It lets a producer hand single words to a consumer with no separate flag variable. A synchronizing store is accepted only when the word is empty, and it leaves the word full. A synchronizing load is accepted only when the word is full, and it leaves the word empty. A request that cannot complete at once is refused with a retry status. Nothing is held inside the block, so the requester decides when to try again.

There is one request port, which takes a valid strobe, an operation code, an address and write data. Every accepted request gets a registered response one cycle later. The response carries read data, a two-bit status, and the word's flag as it stood before the request. Besides the two synchronizing operations, there are plain loads and stores that ignore the flag and leave it as it is, and an operation that writes the flag directly. The flag test, the data access and the flag update all happen at one clock edge, so no other request can fall between them.

Top module: `fe_mem`

## Requirements
- R1: Asynchronous reset makes every presence flag empty and holds rsp_valid_o low. Data contents after reset are not defined.
- R2: Each request accepted with req_valid_i high at a rising edge gives exactly one response, with rsp_valid_o high, after that same edge. No response appears in a cycle without a request.
- R3: A synchronizing store (op 3'd0) to an empty word writes req_wdata_i, sets the flag full, and returns status 2'b00.
- R4: A synchronizing store to a full word returns status 2'b01 (retry) and leaves both the data and the flag unchanged.
- R5: A synchronizing load (op 3'd1) from a full word returns the stored data, sets the flag empty, and returns status 2'b00.
- R6: A synchronizing load from an empty word returns status 2'b01, read data of zero, and leaves the flag unchanged.
- R7: A plain load (op 3'd3) returns the stored data with status 2'b00 and does not change the flag.
- R8: A plain store (op 3'd2) writes the data with status 2'b00 and does not change the flag. Store operations return read data of zero.
- R9: The flag-write operation (op 3'd4) sets the flag to req_wdata_i[0], returns status 2'b00, and leaves the data unchanged.
- R10: Op codes 3'd5 to 3'd7 return status 2'b10 (illegal) with read data of zero and change no data and no flag.
- R11: A request in the cycle right after another request to the same address sees the flag and data that the earlier request left.
- R12: rsp_full_o gives the addressed word's flag as it stood before the request was applied (1 = full).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Operation code |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Store data; bit 0 is the flag value for flag-write |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_status_o | output | 2 | 00 ok, 01 retry, 10 illegal |
| rsp_full_o | output | 1 | Flag of the word before the request |
| rsp_rdata_o | output | DATA_W | Read data, zero for everything other than a successful load |

## Verification
Every result, including status, read data and the prior flag, is registered at the edge that accepts the request. The bench drives each request at a falling edge and samples the response one time unit after the next rising edge. A new request is driven at every falling edge, so requests to the same word arrive back to back. The effect of each request on the flag and data is therefore seen in the very next response. To check that a refused or ignored operation left the word alone, the bench follows it with a plain load, which brings out both the data and the flag at the next sample point.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;
  typedef enum logic [2:0] {
    OP_SYNC_WR = 3'd0,
    OP_SYNC_RD = 3'd1,
    OP_RAW_WR  = 3'd2,
    OP_RAW_RD  = 3'd3,
    OP_SET_TAG = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_RETRY   = 2'b01,
    ST_ILLEGAL = 2'b10
  } status_e;

  typedef struct packed {
    logic    data_we;
    logic    tag_we;
    logic    tag_val;
    logic    ret_data;
    status_e status;
  } ctl_t;
endpackage

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             val_i,
  output logic [DEPTH-1:0] tags_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         tags_o[g] <= 1'b0;
      else if (we_i && idx_i == IDX_W'(g)) tags_o[g] <= val_i;
    end
  end
endmodule

// File: rtl/fe_data_array.sv
module fe_data_array #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/fe_decode.sv
module fe_decode
  import fe_mem_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       full_i,
  input  logic       set_val_i,
  output ctl_t       ctl_o
);
  always_comb begin
    ctl_o = '{data_we: 1'b0, tag_we: 1'b0, tag_val: 1'b0,
              ret_data: 1'b0, status: ST_OK};
    unique case (op_i)
      OP_SYNC_WR: begin
        if (full_i) ctl_o.status = ST_RETRY;
        else begin
          ctl_o.data_we = 1'b1;
          ctl_o.tag_we  = 1'b1;
          ctl_o.tag_val = 1'b1;
        end
      end
      OP_SYNC_RD: begin
        if (!full_i) ctl_o.status = ST_RETRY;
        else begin
          ctl_o.ret_data = 1'b1;
          ctl_o.tag_we   = 1'b1;
          ctl_o.tag_val  = 1'b0;
        end
      end
      OP_RAW_WR: ctl_o.data_we = 1'b1;
      OP_RAW_RD: ctl_o.ret_data = 1'b1;
      OP_SET_TAG: begin
        ctl_o.tag_we  = 1'b1;
        ctl_o.tag_val = set_val_i;
      end
      default: ctl_o.status = ST_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/fe_mem.sv
module fe_mem
  import fe_mem_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic              rsp_full_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0]  tag_q;
  logic [DATA_W-1:0] rd_word;
  logic              cur_full;
  ctl_t              ctl;

  assign cur_full = tag_q[req_addr_i];

  fe_decode u_dec (
    .op_i     (req_op_i),
    .full_i   (cur_full),
    .set_val_i(req_wdata_i[0]),
    .ctl_o    (ctl)
  );

  fe_tag_array #(.DEPTH(DEPTH)) u_tags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (req_valid_i && ctl.tag_we),
    .idx_i (req_addr_i),
    .val_i (ctl.tag_val),
    .tags_o(tag_q)
  );

  fe_data_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk_i  (clk_i),
    .we_i   (req_valid_i && ctl.data_we),
    .idx_i  (req_addr_i),
    .wdata_i(req_wdata_i),
    .rdata_o(rd_word)
  );

  // response captured at the same edge that applies the update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= ST_OK;
      rsp_full_o   <= 1'b0;
      rsp_rdata_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_status_o <= ctl.status;
        rsp_full_o   <= cur_full;
        rsp_rdata_o  <= ctl.ret_data ? rd_word : '0;
      end
    end
  end
endmodule

// File: rtl/fe_mem_checker.sv
module fe_mem_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [2:0]        req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic [1:0]        rsp_status_o,
  input logic              rsp_full_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic [DEPTH-1:0]  tag_q
);
  assert_rsp_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_sync_wr_ok_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 3'd0 && !tag_q[req_addr_i])
    |=> (tag_q[$past(req_addr_i)] && rsp_status_o == 2'b00));
  assert_sync_wr_retry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 3'd0 && tag_q[req_addr_i])
    |=> (rsp_status_o == 2'b01 && $stable(tag_q)));
  assert_sync_rd_ok_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 3'd1 && tag_q[req_addr_i])
    |=> (!tag_q[$past(req_addr_i)] && rsp_status_o == 2'b00));
  assert_sync_rd_retry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 3'd1 && !tag_q[req_addr_i])
    |=> (rsp_status_o == 2'b01 && rsp_rdata_o == '0 && $stable(tag_q)));
  assert_raw_keeps_tag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_op_i == 3'd2 || req_op_i == 3'd3)) |=> $stable(tag_q));
  assert_illegal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i > 3'd4)
    |=> (rsp_status_o == 2'b10 && $stable(tag_q) && rsp_rdata_o == '0));
  assert_prior_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_full_o == $past(tag_q[req_addr_i])));
endmodule

bind fe_mem fe_mem_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_status_o(rsp_status_o),
  .rsp_full_o  (rsp_full_o),
  .rsp_rdata_o (rsp_rdata_o),
  .tag_q       (tag_q)
);

// File: tb/tb_fe_mem.sv
module tb_fe_mem;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int NVEC = 20;

  // {op, addr, wdata, exp_status, exp_full, exp_rdata}
  localparam logic [41:0] VEC [NVEC] = '{
    {3'd0, 4'd3, 16'h1111, 2'b00, 1'b0, 16'h0000}, // R3
    {3'd0, 4'd3, 16'h2222, 2'b01, 1'b1, 16'h0000}, // R4 R11
    {3'd3, 4'd3, 16'h0000, 2'b00, 1'b1, 16'h1111}, // R7 R4 data kept
    {3'd1, 4'd3, 16'h0000, 2'b00, 1'b1, 16'h1111}, // R5
    {3'd1, 4'd3, 16'h0000, 2'b01, 1'b0, 16'h0000}, // R6 R11
    {3'd3, 4'd3, 16'h0000, 2'b00, 1'b0, 16'h1111}, // R7
    {3'd0, 4'd3, 16'h3333, 2'b00, 1'b0, 16'h0000}, // R3
    {3'd2, 4'd5, 16'hABCD, 2'b00, 1'b0, 16'h0000}, // R8
    {3'd3, 4'd5, 16'h0000, 2'b00, 1'b0, 16'hABCD}, // R8 tag still empty
    {3'd4, 4'd5, 16'h0001, 2'b00, 1'b0, 16'h0000}, // R9
    {3'd3, 4'd5, 16'h0000, 2'b00, 1'b1, 16'hABCD}, // R9 data kept
    {3'd1, 4'd5, 16'h0000, 2'b00, 1'b1, 16'hABCD}, // R5
    {3'd5, 4'd3, 16'hFFFF, 2'b10, 1'b1, 16'h0000}, // R10
    {3'd7, 4'd3, 16'hFFFF, 2'b10, 1'b1, 16'h0000}, // R10
    {3'd1, 4'd3, 16'h0000, 2'b00, 1'b1, 16'h3333}, // R10 nothing changed
    {3'd2, 4'd3, 16'h4444, 2'b00, 1'b0, 16'h0000}, // R8
    {3'd3, 4'd3, 16'h0000, 2'b00, 1'b0, 16'h4444}, // R8
    {3'd4, 4'd3, 16'h0000, 2'b00, 1'b0, 16'h0000}, // R9
    {3'd4, 4'd3, 16'h0001, 2'b00, 1'b0, 16'h0000}, // R9 R12
    {3'd1, 4'd3, 16'h0000, 2'b00, 1'b1, 16'h4444}  // R5 R12
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [2:0]        req_op_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_wdata_i = '0;
  logic              rsp_valid_o;
  logic [1:0]        rsp_status_o;
  logic              rsp_full_o;
  logic [DATA_W-1:0] rsp_rdata_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fe_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] wd);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_op_i    = op;
    req_addr_i  = a;
    req_wdata_i = wd;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 rsp_valid in reset", 32'(rsp_valid_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: every flag empty after reset
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      issue(3'd3, ADDR_W'(a), '0);
      check("R1 flag empty", 32'(rsp_full_o), 32'd0);
    end

    // table walk, back to back (R11)
    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][41:39], VEC[i][38:35], VEC[i][34:19]);
      check($sformatf("R2 valid vec%0d", i), 32'(rsp_valid_o), 32'd1);
      check($sformatf("status vec%0d", i), 32'(rsp_status_o), 32'(VEC[i][18:17]));
      check($sformatf("R12 full vec%0d", i), 32'(rsp_full_o), 32'(VEC[i][16]));
      check($sformatf("rdata vec%0d", i), 32'(rsp_rdata_o), 32'(VEC[i][15:0]));
    end

    // R2: idle cycle gives no response
    @(negedge clk_i);
    req_valid_i = 1'b0;
    @(posedge clk_i);
    #1;
    check("R2 no response when idle", 32'(rsp_valid_o), 32'd0);

    // R4 on a second word: fill, refuse, confirm data
    issue(3'd0, 4'd9, 16'h0A0A);
    check("R3 fill word 9", 32'(rsp_status_o), 32'd0);
    issue(3'd0, 4'd9, 16'h0B0B);
    check("R4 refuse word 9", 32'(rsp_status_o), 32'd1);
    issue(3'd3, 4'd9, '0);
    check("R4 data kept word 9", 32'(rsp_rdata_o), 32'h0A0A);

    // R1: reset in mid-run clears flags set above
    @(negedge clk_i);
    req_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R1 async reset valid", 32'(rsp_valid_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    issue(3'd1, 4'd9, '0);
    check("R1 flag cleared word 9", 32'(rsp_full_o), 32'd0);
    check("R6 retry after reset", 32'(rsp_status_o), 32'd1);
    issue(3'd3, 4'd5, '0);
    check("R1 flag cleared word 5", 32'(rsp_full_o), 32'd0);

    @(negedge clk_i);
    req_valid_i = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule